// File: doc/BRIEF.md
# Tiered Write-Once Register Lock

This block guards the configuration fields of a timer's complementary-output stage against accidental rewrites. A 2-bit protection level chooses one of four tiers. The tiers are cumulative: each one blocks everything the tier below it blocks, then adds more fields. Break and dead-time settings lock first. Channel polarity and the off-state selects lock next. The output-compare mode settings lock last. The polarity and compare locks apply only to channels that are currently outputs. The protection level can be set only once after reset: the first write to the register that holds it captures it, and it then stays fixed until the next reset.

The block holds the controlled fields itself and accepts one write strobe per register group. It applies each write bit by bit through a per-bit write-enable mask. The same masks are presented on output ports, so a neighbouring register file can apply the same policy. A write to a locked bit is dropped silently, and no error is raised.

Top module: `tier_wlock`

## Requirements
- R1: While reset is held and after it is released, every stored field reads zero. The level reads 00 and the freeze flag reads 0. Every write-enable output bit reads 1.
- R2: The configuration word has this layout: bits [7:0] dead time, bit 8 break enable, bit 9 break polarity, bit 10 automatic output enable, bit 11 idle-mode off-state select, bit 12 run-mode off-state select, bits [14:13] protection level. At level 00, a strobed write to any of the four registers replaces every bit of that register on the next clock edge.
- R3: The first configuration strobe after reset loads bits [14:13] into the level and sets the freeze flag. Later configuration strobes leave the level unchanged until reset.
- R4: At level 01 or above, writes to the following are dropped: dead time, break enable, break polarity, automatic output enable, and the whole idle-state register. The idle-state register holds bits 2c and 2c+1 for channel c.
- R5: At level 10 or above, writes to both off-state selects are dropped. Writes to the polarity register are also dropped, for output channels only. The polarity register holds bits 2c (main) and 2c+1 (complementary) for channel c.
- R6: At level 11, writes to the compare register are dropped for output channels. For channel c, compare bits [4c+2:4c] hold the mode and bit 4c+3 holds the shadow enable.
- R7: The break-enable bit can change only while the level is 00.
- R8: A channel whose chan_out bit is 0 keeps its polarity and compare bits writable at every level.
- R9: Locking works bit by bit. Within a single write, unlocked bits update and locked bits keep their old value.
- R10: A write strobed in the same cycle as the level-setting write is judged against the level that held before that edge.
- R11: The wen_* outputs show, for the current level, freeze flag and chan_out, which bits a write would change (1 = writable). The level bits of wen_cfg are 1 only while the level is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_out | input | NCH | Per-channel output-mode status (1 = output) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 15 | Configuration write data |
| idle_we | input | 1 | Idle-state register write strobe |
| idle_wdata | input | 2*NCH | Idle-state write data |
| pol_we | input | 1 | Polarity register write strobe |
| pol_wdata | input | 2*NCH | Polarity write data |
| cmp_we | input | 1 | Compare-mode register write strobe |
| cmp_wdata | input | NCH*CMPW | Compare-mode write data |
| cfg_q | output | 15 | Configuration register contents, level included |
| idle_q | output | 2*NCH | Idle-state register contents |
| pol_q | output | 2*NCH | Polarity register contents |
| cmp_q | output | NCH*CMPW | Compare-mode register contents |
| level_q | output | 2 | Current protection level |
| level_frozen | output | 1 | Level has been captured since reset |
| wen_cfg | output | 15 | Per-bit write enable, configuration register |
| wen_idle | output | 2*NCH | Per-bit write enable, idle-state register |
| wen_pol | output | 2*NCH | Per-bit write enable, polarity register |
| wen_cmp | output | NCH*CMPW | Per-bit write enable, compare-mode register |

## Verification
Write sequences run at each of the four levels. Each sequence begins with the level-setting write and then strikes every register with all-ones and with mixed patterns. This separates a tier that locks too little from one that locks too much. Channel-mask patterns such as 0101, 1001 and 0000 show whether the polarity and compare locks follow chan_out channel by channel rather than as a whole. Two further cases are distinct. A first write of level 00 must still freeze the level. A polarity write in the same cycle as the level write must still land, which shows the locks follow the old level for one edge.

// File: rtl/twl_pkg.sv
package twl_pkg;
  localparam int CFG_W      = 15;
  localparam int DT_LSB     = 0;
  localparam int DT_W       = 8;
  localparam int BRK_EN_B   = 8;
  localparam int BRK_POL_B  = 9;
  localparam int AUTO_OE_B  = 10;
  localparam int IDLE_OFF_B = 11;
  localparam int RUN_OFF_B  = 12;
  localparam int LVL_LSB    = 13;
  localparam int LVL_W      = 2;
  localparam int BANK_W     = LVL_LSB;

  typedef enum logic [1:0] {
    LVL_OPEN  = 2'b00,
    LVL_BASIC = 2'b01,
    LVL_MID   = 2'b10,
    LVL_FULL  = 2'b11
  } lvl_e;
endpackage

// File: rtl/twl_level.sv
module twl_level
  import twl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LVL_W-1:0] wdata,
  output logic [LVL_W-1:0] level,
  output logic             frozen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= '0;
      frozen <= 1'b0;
    end else if (we && !frozen) begin
      level  <= wdata;
      frozen <= 1'b1;
    end
  end

  // R3
  frozen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> frozen);
  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(level));
  // R3
  freeze_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> $past(we));
endmodule

// File: rtl/twl_policy.sv
module twl_policy
  import twl_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CMPW = 4
) (
  input  logic [LVL_W-1:0]     level,
  input  logic                 frozen,
  input  logic [NCH-1:0]       chan_out,
  output logic [CFG_W-1:0]     wen_cfg,
  output logic [2*NCH-1:0]     wen_idle,
  output logic [2*NCH-1:0]     wen_pol,
  output logic [NCH*CMPW-1:0]  wen_cmp
);
  logic tier1, tier2, tier3;

  always_comb begin
    tier1 = (lvl_e'(level) != LVL_OPEN);
    tier2 = (lvl_e'(level) == LVL_MID) || (lvl_e'(level) == LVL_FULL);
    tier3 = (lvl_e'(level) == LVL_FULL);
  end

  always_comb begin
    wen_cfg = '0;
    wen_cfg[DT_LSB +: DT_W]        = {DT_W{~tier1}};
    wen_cfg[BRK_EN_B]              = ~tier1;
    wen_cfg[BRK_POL_B]             = ~tier1;
    wen_cfg[AUTO_OE_B]             = ~tier1;
    wen_cfg[IDLE_OFF_B]            = ~tier2;
    wen_cfg[RUN_OFF_B]             = ~tier2;
    wen_cfg[LVL_LSB +: LVL_W]      = {LVL_W{~frozen}};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wen_idle[2*c +: 2]       = {2{~tier1}};
    assign wen_pol[2*c +: 2]        = {2{~(tier2 & chan_out[c])}};
    assign wen_cmp[c*CMPW +: CMPW]  = {CMPW{~(tier3 & chan_out[c])}};
  end
endmodule

// File: rtl/twl_bank.sv
module twl_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] en,
  output logic [W-1:0] q
);
  logic [W-1:0] mask;

  always_comb mask = en & {W{we}};

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~mask) | (wdata & mask);
  end

  // R9
  locked_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (((q ^ $past(q)) & ~$past(en)) == '0));
  // R9
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/tier_wlock.sv
module tier_wlock
  import twl_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CMPW = 4,
  localparam int PW  = 2*NCH,
  localparam int CW  = NCH*CMPW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   chan_out,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             idle_we,
  input  logic [PW-1:0]    idle_wdata,
  input  logic             pol_we,
  input  logic [PW-1:0]    pol_wdata,
  input  logic             cmp_we,
  input  logic [CW-1:0]    cmp_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [PW-1:0]    idle_q,
  output logic [PW-1:0]    pol_q,
  output logic [CW-1:0]    cmp_q,
  output logic [1:0]       level_q,
  output logic             level_frozen,
  output logic [CFG_W-1:0] wen_cfg,
  output logic [PW-1:0]    wen_idle,
  output logic [PW-1:0]    wen_pol,
  output logic [CW-1:0]    wen_cmp
);
  logic [BANK_W-1:0] bank_q;

  twl_level u_level (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata[LVL_LSB +: LVL_W]),
    .level  (level_q),
    .frozen (level_frozen)
  );

  twl_policy #(.NCH(NCH), .CMPW(CMPW)) u_policy (
    .level    (level_q),
    .frozen   (level_frozen),
    .chan_out (chan_out),
    .wen_cfg  (wen_cfg),
    .wen_idle (wen_idle),
    .wen_pol  (wen_pol),
    .wen_cmp  (wen_cmp)
  );

  twl_bank #(.W(BANK_W)) u_cfg (
    .clk (clk), .rst (rst), .we (cfg_we),
    .wdata (cfg_wdata[BANK_W-1:0]), .en (wen_cfg[BANK_W-1:0]), .q (bank_q)
  );

  twl_bank #(.W(PW)) u_idle (
    .clk (clk), .rst (rst), .we (idle_we),
    .wdata (idle_wdata), .en (wen_idle), .q (idle_q)
  );

  twl_bank #(.W(PW)) u_pol (
    .clk (clk), .rst (rst), .we (pol_we),
    .wdata (pol_wdata), .en (wen_pol), .q (pol_q)
  );

  twl_bank #(.W(CW)) u_cmp (
    .clk (clk), .rst (rst), .we (cmp_we),
    .wdata (cmp_wdata), .en (wen_cmp), .q (cmp_q)
  );

  assign cfg_q = {level_q, bank_q};

  // R7
  brk_en_open_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q[BRK_EN_B]) |-> ($past(level_q) == 2'b00));
  // R5
  off_sel_tier_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q[RUN_OFF_B:IDLE_OFF_B]) |-> !$past(level_q[1]));
  // R4
  dead_time_tier_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q[DT_LSB +: DT_W]) |-> ($past(level_q) == 2'b00));
endmodule

// File: tb/tb_tier_wlock.sv
module tb_tier_wlock;
  localparam int NCH = 4;
  localparam int CMPW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  chan_out = '0;
  logic        cfg_we = 1'b0, idle_we = 1'b0, pol_we = 1'b0, cmp_we = 1'b0;
  logic [14:0] cfg_wdata = '0;
  logic [7:0]  idle_wdata = '0, pol_wdata = '0;
  logic [15:0] cmp_wdata = '0;
  logic [14:0] cfg_q, wen_cfg;
  logic [7:0]  idle_q, pol_q, wen_idle, wen_pol;
  logic [15:0] cmp_q, wen_cmp;
  logic [1:0]  level_q;
  logic        level_frozen;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tier_wlock #(.NCH(NCH), .CMPW(CMPW)) dut (
    .clk, .rst, .chan_out,
    .cfg_we, .cfg_wdata, .idle_we, .idle_wdata,
    .pol_we, .pol_wdata, .cmp_we, .cmp_wdata,
    .cfg_q, .idle_q, .pol_q, .cmp_q, .level_q, .level_frozen,
    .wen_cfg, .wen_idle, .wen_pol, .wen_cmp
  );

  typedef struct packed {
    logic        rs;
    logic [1:0]  sel;
    logic [15:0] d;
    logic [3:0]  co;
    logic [15:0] exp_q;
    logic [1:0]  exp_lv;
    logic [3:0]  req;
  } vec_t;

  // sel: 0 cfg, 1 idle, 2 pol, 3 cmp
  localparam vec_t TBL [20] = '{
    '{1'b1, 2'd1, 16'h00A5, 4'hF, 16'h00A5, 2'd0, 4'd2},  // R2 open idle
    '{1'b0, 2'd2, 16'h003C, 4'hF, 16'h003C, 2'd0, 4'd2},  // R2 open pol
    '{1'b0, 2'd3, 16'h1234, 4'hF, 16'h1234, 2'd0, 4'd2},  // R2 open cmp
    '{1'b0, 2'd0, 16'h2F5A, 4'hF, 16'h2F5A, 2'd1, 4'd3},  // R3 set level 01
    '{1'b0, 2'd0, 16'h0000, 4'hF, 16'h275A, 2'd1, 4'd4},  // R4 tier1 locks, off-sel free
    '{1'b0, 2'd1, 16'h0000, 4'hF, 16'h00A5, 2'd1, 4'd4},  // R4 idle locked
    '{1'b0, 2'd2, 16'h00FF, 4'hF, 16'h00FF, 2'd1, 4'd4},  // R4 pol still free
    '{1'b0, 2'd3, 16'hFFFF, 4'hF, 16'hFFFF, 2'd1, 4'd4},  // R4 cmp still free
    '{1'b1, 2'd0, 16'h5011, 4'hF, 16'h5011, 2'd2, 4'd3},  // R3 set level 10
    '{1'b0, 2'd0, 16'h7FFF, 4'hF, 16'h5011, 2'd2, 4'd5},  // R5 all cfg locked
    '{1'b0, 2'd2, 16'h00FF, 4'h5, 16'h00CC, 2'd2, 4'd8},  // R8 pol per channel
    '{1'b0, 2'd3, 16'hFFFF, 4'hF, 16'hFFFF, 2'd2, 4'd5},  // R5 cmp free at 10
    '{1'b0, 2'd1, 16'h00FF, 4'hF, 16'h0000, 2'd2, 4'd4},  // R4 idle locked at 10
    '{1'b1, 2'd0, 16'h6000, 4'hF, 16'h6000, 2'd3, 4'd3},  // R3 set level 11
    '{1'b0, 2'd3, 16'hABCD, 4'h9, 16'h0BC0, 2'd3, 4'd6},  // R6 cmp per channel
    '{1'b0, 2'd2, 16'h00FF, 4'h0, 16'h00FF, 2'd3, 4'd8},  // R8 input channels free
    '{1'b0, 2'd3, 16'hFFFF, 4'h0, 16'hFFFF, 2'd3, 4'd8},  // R8 cmp input channels
    '{1'b1, 2'd0, 16'h0000, 4'hF, 16'h0000, 2'd0, 4'd3},  // R3 first write level 00
    '{1'b0, 2'd0, 16'h6100, 4'hF, 16'h0100, 2'd0, 4'd7},  // R7 brk_en at 00, level frozen
    '{1'b0, 2'd3, 16'h5555, 4'hF, 16'h5555, 2'd0, 4'd9}   // R9 still open
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [15:0] d, input logic [3:0] co);
    @(negedge clk);
    chan_out = co;
    cfg_wdata = d[14:0]; idle_wdata = d[7:0]; pol_wdata = d[7:0]; cmp_wdata = d;
    cfg_we = (sel == 2'd0); idle_we = (sel == 2'd1);
    pol_we = (sel == 2'd2); cmp_we = (sel == 2'd3);
    @(negedge clk);
    cfg_we = 1'b0; idle_we = 1'b0; pol_we = 1'b0; cmp_we = 1'b0;
  endtask

  function automatic logic [15:0] readback(input logic [1:0] sel);
    case (sel)
      2'd0:    return {1'b0, cfg_q};
      2'd1:    return {8'h00, idle_q};
      2'd2:    return {8'h00, pol_q};
      default: return cmp_q;
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 cfg_q", {1'b0, cfg_q}, 16'h0000);
    check("R1 idle/pol", {idle_q, pol_q}, 16'h0000);
    check("R1 cmp_q", cmp_q, 16'h0000);
    check("R1 level/frozen", {13'd0, level_frozen, level_q}, 16'h0000);
    check("R1 wen_cfg", {1'b0, wen_cfg}, 16'h7FFF);
    check("R1 wen_idle/pol", {wen_idle, wen_pol}, 16'hFFFF);
    check("R1 wen_cmp", wen_cmp, 16'hFFFF);

    for (int i = 0; i < 20; i++) begin
      if (TBL[i].rs) do_reset();
      do_write(TBL[i].sel, TBL[i].d, TBL[i].co);
      check($sformatf("R%0d vec %0d data", TBL[i].req, i), readback(TBL[i].sel), TBL[i].exp_q);
      check($sformatf("R%0d vec %0d level", TBL[i].req, i), {14'd0, level_q}, {14'd0, TBL[i].exp_lv});
    end

    // R10: polarity write in same cycle as level-10 write uses old level
    do_reset();
    @(negedge clk);
    chan_out = 4'hF;
    cfg_wdata = 15'h4000; pol_wdata = 8'hFF;
    cfg_we = 1'b1; pol_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; pol_we = 1'b0;
    check("R10 same-cycle pol", {8'h00, pol_q}, 16'h00FF);
    check("R3 frozen set", {15'd0, level_frozen}, 16'h0001);
    do_write(2'd2, 16'h0000, 4'hF);
    check("R5 pol locked after", {8'h00, pol_q}, 16'h00FF);

    // R11: enable outputs at level 01
    do_reset();
    do_write(2'd0, 16'h2000, 4'hF);
    check("R11 wen_cfg lvl01", {1'b0, wen_cfg}, 16'h1800);
    check("R11 wen_idle lvl01", {8'h00, wen_idle}, 16'h0000);

    // R11: enable outputs at level 11 with chan 1 an output
    do_reset();
    do_write(2'd0, 16'h6000, 4'h2);
    check("R11 wen_cfg lvl11", {1'b0, wen_cfg}, 16'h0000);
    check("R11 wen_pol lvl11", {8'h00, wen_pol}, 16'h00F3);
    check("R11 wen_cmp lvl11", wen_cmp, 16'hFF0F);
    @(negedge clk);
    chan_out = 4'h0;
    #1;
    check("R8 wen_pol inputs", {8'h00, wen_pol}, 16'h00FF);
    check("R8 wen_cmp inputs", wen_cmp, 16'hFFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule